// File: doc/BRIEF.md
# Selectable-Half Limb Multiplier

This block is a multi-cycle unsigned multiplier for two 64-bit operands. It returns one half of the 128-bit product, either the lower or the upper 64 bits, chosen by a select input when the operation starts. Each operand is split into four 16-bit limbs, giving sixteen possible limb products, but the block has only ten 16x16 multipliers.

The lower half needs the ten products whose limb indices sum to three or less. The upper half needs the ten products whose indices sum to three or more. Both sets share the four products on the diagonal where the indices sum to three. In upper mode, the multiplier inputs are steered to the mirrored limbs: the pair (i, j) becomes (3-j, 3-i). The products are then summed along a column arrangement that matches the selected mode.

The upper half must be exact, so it cannot ignore the carry that comes up from the lower columns. An upper request therefore runs two passes through the same hardware:
- The first pass uses lower steering and keeps the carry that leaves the columns below the diagonal.
- The second pass uses upper steering. It adds that carry to the diagonal and upper columns.

The block has a start/busy/done handshake. The pipeline stage that issues the operation holds until done is asserted.

The controller is a five-state machine:
- `ST_IDLE` waits for start. On start it captures the operands and the half select, then moves to `ST_PROD`.
- `ST_PROD` registers the ten limb products. It moves to `ST_COLSUM`.
- `ST_COLSUM` registers four column sums. It moves to `ST_MERGE`.
- `ST_MERGE` shifts and adds the column sums. For an upper request on its first pass, it stores the carry and loops back to `ST_PROD` for the second pass. Otherwise it writes the result register and moves to `ST_DONE`.
- `ST_DONE` asserts done for one cycle and returns to `ST_IDLE`.

Top module: `halfsel_mul`

## Requirements
- R1: While reset is asserted and right after it is released, busy is 0, done is 0 and result is 0.
- R2: With half_sel = 0 at start, result becomes the product op_a*op_b modulo 2^(4*LIMB_W), that is, bits [4*LIMB_W-1:0] of the full product.
- R3: With half_sel = 1 at start, result becomes bits [8*LIMB_W-1:4*LIMB_W] of the full product. This is exact, including every carry from the lower columns.
- R4: A lower-half operation accepted at a rising edge raises done after the 3rd following rising edge, so done is high in the 3rd cycle after acceptance.
- R5: An upper-half operation raises done after the 6th rising edge that follows acceptance.
- R6: Done is high for exactly one cycle. Busy is high in every cycle from the one after acceptance through the done cycle, and it is low in the cycle after done.
- R7: Start is accepted only while busy is 0. A start, operand or half_sel change while busy does not alter the result, the latency or the number of done pulses.
- R8: Result changes only in a cycle where done is high, and it holds its value until the next completion.
- R9: Operands and half_sel are sampled at the accepting edge only. Later changes on op_a, op_b or half_sel do not affect the operation in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; accepted when busy is 0 |
| half_sel | input | 1 | 0 selects the lower product half, 1 selects the upper half |
| op_a | input | 4*LIMB_W | Multiplicand, unsigned |
| op_b | input | 4*LIMB_W | Multiplier, unsigned |
| busy | output | 1 | Operation in flight, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 4*LIMB_W | Selected product half, held until the next completion |

## Verification
The bench builds the block with LIMB_W = 4, so the operands are 16 bits and the full product fits in 32 bits. The bench can then compute the reference product directly and compare both halves.

One operand sweeps every combination of four limbs, each taken from zero, one, the two values either side of mid-scale, and all-ones. It is paired with a set of fixed opposite operands in both modes. This covers every carry pattern that can cross from the low columns into the upper half with saturated and near-saturated limbs.

Because the limbs are narrow, each run also exercises the two-pass looping of the state machine, the intrusion of start while busy, and operand changes after acceptance.

// File: rtl/halfsel_mul_pkg.sv
package halfsel_mul_pkg;

    localparam int NLIMB = 4;
    localparam int NSLOT = 10;
    localparam int NCOL  = 4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PROD   = 3'd1,
        ST_COLSUM = 3'd2,
        ST_MERGE  = 3'd3,
        ST_DONE   = 3'd4
    } mul_state_e;

    // Slots are ordered by column (index sum) in lower mode:
    // slot 0 -> column 0, slots 1..2 -> column 1,
    // slots 3..5 -> column 2, slots 6..9 -> column 3.
    function automatic int slot_col(input int s);
        if (s < 1)      return 0;
        else if (s < 3) return 1;
        else if (s < 6) return 2;
        else            return 3;
    endfunction

    // Lower-mode A limb index of a slot.
    function automatic int slot_a(input int s);
        int c;
        c = slot_col(s);
        return c - (s - (c * (c + 1)) / 2);
    endfunction

    // Lower-mode B limb index of a slot.
    function automatic int slot_b(input int s);
        int c;
        c = slot_col(s);
        return s - (c * (c + 1)) / 2;
    endfunction

endpackage

// File: rtl/halfsel_prod.sv
// Ten steered limb multipliers with registered products.
// Upper mode maps lower pair (i, j) onto (3-j, 3-i).
module halfsel_prod
    import halfsel_mul_pkg::*;
#(
    parameter int LIMB_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic                              sel_hi,
    input  logic [NLIMB*LIMB_W-1:0]           a,
    input  logic [NLIMB*LIMB_W-1:0]           b,
    output logic [NSLOT-1:0][2*LIMB_W-1:0]    prod
);

    localparam int PW = 2 * LIMB_W;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam int IA = slot_a(s);
        localparam int IB = slot_b(s);

        logic [LIMB_W-1:0] la;
        logic [LIMB_W-1:0] lb;

        always_comb begin
            if (sel_hi) begin
                la = a[(NLIMB-1-IB)*LIMB_W +: LIMB_W];
                lb = b[(NLIMB-1-IA)*LIMB_W +: LIMB_W];
            end else begin
                la = a[IA*LIMB_W +: LIMB_W];
                lb = b[IB*LIMB_W +: LIMB_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prod[s] <= '0;
            end else if (load) begin
                prod[s] <= PW'(la) * PW'(lb);
            end
        end
    end

endmodule

// File: rtl/halfsel_colsum.sv
// Registered column sums: one group per column of the lower ordering.
module halfsel_colsum
    import halfsel_mul_pkg::*;
#(
    parameter int LIMB_W = 16,
    parameter int GW     = 2 * LIMB_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [NSLOT-1:0][2*LIMB_W-1:0] prod,
    output logic [NCOL-1:0][GW-1:0]        grp
);

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic [GW-1:0] sum;

        always_comb begin
            sum = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (slot_col(s) == c) begin
                    sum = sum + GW'(prod[s]);
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp[c] <= '0;
            end else if (load) begin
                grp[c] <= sum;
            end
        end
    end

endmodule

// File: rtl/halfsel_merge.sv
// Shift-and-add of the column groups, arranged per mode.
// Lower: g0 + g1<<L + g2<<2L + g3<<3L, carry = (g0 + g1<<L + g2<<2L) >> 3L.
// Upper: (carry + g3 + g2<<L + g1<<2L + g0<<3L) >> L.
module halfsel_merge
    import halfsel_mul_pkg::*;
#(
    parameter int LIMB_W = 16,
    parameter int GW     = 2 * LIMB_W + 2,
    parameter int CW     = LIMB_W + 2
) (
    input  logic [NCOL-1:0][GW-1:0]    grp,
    input  logic [CW-1:0]              carry_in,
    output logic [NLIMB*LIMB_W-1:0]    lo_word,
    output logic [NLIMB*LIMB_W-1:0]    hi_word,
    output logic [CW-1:0]              carry_out
);

    localparam int W     = NLIMB * LIMB_W;
    localparam int ACC_W = 5 * LIMB_W + 4;

    logic [ACC_W-1:0] g0, g1, g2, g3;
    logic [ACC_W-1:0] below_diag;
    logic [ACC_W-1:0] upper_acc;

    always_comb begin
        g0 = ACC_W'(grp[0]);
        g1 = ACC_W'(grp[1]);
        g2 = ACC_W'(grp[2]);
        g3 = ACC_W'(grp[3]);

        below_diag = g0 + (g1 << LIMB_W) + (g2 << (2 * LIMB_W));
        lo_word    = W'(below_diag + (g3 << (3 * LIMB_W)));
        carry_out  = CW'(below_diag >> (3 * LIMB_W));

        upper_acc  = ACC_W'(carry_in) + g3 + (g2 << LIMB_W)
                   + (g1 << (2 * LIMB_W)) + (g0 << (3 * LIMB_W));
        hi_word    = W'(upper_acc >> LIMB_W);
    end

endmodule

// File: rtl/halfsel_mul.sv
module halfsel_mul
    import halfsel_mul_pkg::*;
#(
    parameter int LIMB_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      half_sel,
    input  logic [4*LIMB_W-1:0]       op_a,
    input  logic [4*LIMB_W-1:0]       op_b,
    output logic                      busy,
    output logic                      done,
    output logic [4*LIMB_W-1:0]       result
);

    localparam int W  = NLIMB * LIMB_W;
    localparam int GW = 2 * LIMB_W + 2;
    localparam int CW = LIMB_W + 2;

    mul_state_e state_q, state_d;

    logic [W-1:0]                    a_q, b_q;
    logic                            req_hi_q;
    logic                            pass_hi_q;
    logic [CW-1:0]                   carry_q;
    logic [W-1:0]                    result_q;

    logic [NSLOT-1:0][2*LIMB_W-1:0]  prod;
    logic [NCOL-1:0][GW-1:0]         grp;
    logic [W-1:0]                    m_lo, m_hi;
    logic [CW-1:0]                   m_carry;
    logic                            need_second;

    assign need_second = req_hi_q && !pass_hi_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_PROD;
            ST_PROD:   state_d = ST_COLSUM;
            ST_COLSUM: state_d = ST_MERGE;
            ST_MERGE:  state_d = need_second ? ST_PROD : ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_PROD,
            ST_COLSUM,
            ST_MERGE:  busy = 1'b1;
            ST_DONE:   done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign result = result_q;

    // Operand capture, pass tracking and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q       <= '0;
            b_q       <= '0;
            req_hi_q  <= 1'b0;
            pass_hi_q <= 1'b0;
            carry_q   <= '0;
            result_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                a_q       <= op_a;
                b_q       <= op_b;
                req_hi_q  <= half_sel;
                pass_hi_q <= 1'b0;
            end
            if (state_q == ST_MERGE) begin
                if (need_second) begin
                    pass_hi_q <= 1'b1;
                    carry_q   <= m_carry;
                end else begin
                    result_q  <= pass_hi_q ? m_hi : m_lo;
                end
            end
        end
    end

    halfsel_prod #(
        .LIMB_W (LIMB_W)
    ) u_prod (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state_q == ST_PROD),
        .sel_hi (pass_hi_q),
        .a      (a_q),
        .b      (b_q),
        .prod   (prod)
    );

    halfsel_colsum #(
        .LIMB_W (LIMB_W),
        .GW     (GW)
    ) u_colsum (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state_q == ST_COLSUM),
        .prod   (prod),
        .grp    (grp)
    );

    halfsel_merge #(
        .LIMB_W (LIMB_W),
        .GW     (GW),
        .CW     (CW)
    ) u_merge (
        .grp       (grp),
        .carry_in  (carry_q),
        .lo_word   (m_lo),
        .hi_word   (m_hi),
        .carry_out (m_carry)
    );

endmodule

// File: rtl/halfsel_mul_checker.sv
module halfsel_mul_checker #(
    parameter int LIMB_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                half_sel,
    input logic                busy,
    input logic                done,
    input logic [4*LIMB_W-1:0] result
);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_within_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_accept_raises_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_lo_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !half_sel) |-> ##4 done);

    p_hi_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && half_sel) |-> ##7 done);

    p_no_done_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !done);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

bind halfsel_mul halfsel_mul_checker #(
    .LIMB_W (LIMB_W)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .half_sel (half_sel),
    .busy     (busy),
    .done     (done),
    .result   (result)
);

// File: tb/halfsel_mul_bench.sv
module halfsel_mul_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BL         = 4;
    localparam int BW         = 4 * BL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          half_sel = 1'b0;
    logic [BW-1:0] op_a = '0;
    logic [BW-1:0] op_b = '0;
    logic          busy;
    logic          done;
    logic [BW-1:0] result;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    halfsel_mul #(
        .LIMB_W (BL)
    ) u_halfsel_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .half_sel (half_sel),
        .op_a     (op_a),
        .op_b     (op_b),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [BL-1:0] limb_pat(input int k);
        case (k)
            0:       return '0;
            1:       return BL'(1);
            2:       return BL'((1 << (BL-1)) - 1);
            3:       return BL'(1 << (BL-1));
            default: return '1;
        endcase
    endfunction

    function automatic logic [BW-1:0] expect_half(input logic [BW-1:0] a,
                                                  input logic [BW-1:0] b,
                                                  input logic hi);
        logic [2*BW-1:0] full;
        full = {{BW{1'b0}}, a} * {{BW{1'b0}}, b};
        return hi ? full[2*BW-1:BW] : full[BW-1:0];
    endfunction

    // One operation. intrude: pulse start with other operands while busy (R7).
    task automatic run_op(input logic [BW-1:0] a, input logic [BW-1:0] b,
                          input logic hi, input bit intrude);
        int            cyc;
        int            exp_lat;
        logic [BW-1:0] exp_res;
        bit            busy_ok;
        exp_lat = hi ? 6 : 3;
        exp_res = expect_half(a, b, hi);
        @(negedge clk);
        op_a = a; op_b = b; half_sel = hi; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R9: inputs scrambled after the accepting edge
        op_a = ~a; op_b = b ^ 16'h5A5A; half_sel = ~hi; start = intrude;
        cyc = 0;
        busy_ok = 1'b1;
        while (!done && cyc < 12) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
            if (cyc == 2) start = 1'b0;
        end
        check("R6 busy held until done", 64'(busy_ok), 64'd1);
        if (hi) check("R5 upper latency", 64'(cyc), 64'(exp_lat));
        else    check("R4 lower latency", 64'(cyc), 64'(exp_lat));
        if (hi) check("R3 upper half", 64'(result), 64'(exp_res));
        else    check("R2 lower half", 64'(result), 64'(exp_res));
        @(negedge clk);
        check("R6 done one cycle", 64'(done), 64'd0);
        check("R6 busy low after done", 64'(busy), 64'd0);
        check("R8 result held", 64'(result), 64'(exp_res));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy in reset", 64'(busy), 64'd0);
        check("R1 done in reset", 64'(done), 64'd0);
        check("R1 result in reset", 64'(result), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", 64'(busy), 64'd0);
        check("R1 result after reset", 64'(result), 64'd0);

        // R7: start held while busy, other operands, no effect
        run_op(16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
        run_op(16'hFFFF, 16'hFFFF, 1'b0, 1'b1);
        run_op(16'h8001, 16'h7FFF, 1'b1, 1'b1);
        // R9: operands and half changed right after acceptance
        run_op(16'h1234, 16'hFEDC, 1'b0, 1'b0);
        run_op(16'h1234, 16'hFEDC, 1'b1, 1'b0);

        // R8: idle with start low, result must not move
        @(negedge clk);
        op_a = '1; op_b = '1; half_sel = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 result idle hold", 64'(result), 64'(expect_half(16'h1234, 16'hFEDC, 1'b1)));
        check("R7 no spurious done", 64'(done), 64'd0);

        // R2/R3 sweep: every limb pattern of op_a against fixed op_b values
        for (int ia = 0; ia < 625; ia++) begin
            logic [BW-1:0] a;
            a = {limb_pat((ia / 125) % 5), limb_pat((ia / 25) % 5),
                 limb_pat((ia / 5) % 5), limb_pat(ia % 5)};
            for (int jb = 0; jb < 8; jb++) begin
                logic [BW-1:0] b;
                case (jb)
                    0: b = 16'h0000;
                    1: b = 16'h0001;
                    2: b = 16'hFFFF;
                    3: b = 16'h8000;
                    4: b = 16'hF0F0;
                    5: b = 16'h0FFF;
                    6: b = 16'hFFFE;
                    default: b = 16'h7F81;
                endcase
                run_op(a, b, 1'b0, 1'b0);
                run_op(a, b, 1'b1, 1'b0);
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule